// File: doc/BRIEF.md
# Five-Source Bus Master Arbiter

This block decides which of five internal requesters may start the next master transaction on a shared bus. Four requesters are DMA FIFOs: transmit 0 (T0), transmit 1 (T1), receive 0 (R0) and receive 1 (R1). The fifth is a single-access path (S). S is used for lone transfers that skip the FIFOs. A pending S request beats every FIFO request, whatever policy is active.

A two-bit policy input picks how FIFOs compete:

- **Rotating order:** the FIFOs take turns.
- **Programmed priority:** each FIFO carries a two-bit priority value.
- **External decision:** outside logic reads a registered request-status vector and names the winner on a two-bit select input.

The grant is registered and one-hot. It stays asserted until the bus logic pulses the transaction-done input. A new decision is taken only while no grant is held.

Top module: `bus_master_arbiter`

## Requirements
- R1: After synchronous reset, `grant` and `req_status` are zero and the rotating search begins at T0.
- R2: `grant` is zero or one-hot. Its bits are [0]=T0, [1]=T1, [2]=R0, [3]=R1, [4]=S. `fifo_req` uses the same order for bits 3:0. A decision taken at a clock edge with no grant held shows on `grant` right after that edge.
- R3: When `single_req` is high and no grant is held, the next grant is S, in every `policy` value including the reserved one.
- R4: An active grant stays unchanged until `xfer_done` is high at an edge. That edge clears the grant, and the next decision comes no earlier than the following edge.
- R5: With `policy`=00 (rotating), FIFOs are visited in the cyclic order T0, T1, R0, R1. The search starts just after the last FIFO granted, and non-requesting FIFOs are skipped. S grants do not move the rotation.
- R6: With `policy`=01 (priority), the requesting FIFO with the largest value in `prio_vals` wins. The priority of FIFO i (T0=0, T1=1, R0=2, R1=3) sits in bits [2i+1:2i].
- R7: In priority policy, equal values are resolved T0 over T1 over R0 over R1.
- R8: With `policy`=10 (external), `ext_sel` names the winner: 00=R1, 01=R0, 10=T1, 11=T0.
- R9: In external policy, a select naming a FIFO without a pending request yields no grant.
- R10: With `policy`=11 (reserved), no FIFO is ever granted.
- R11: `req_status` is a registered copy of the FIFO requests, one edge late, with bit 0=R1, bit 1=R0, bit 2=T1, bit 3=T0.
- R12: With no request at all and no grant held, `grant` remains zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_req | input | 4 | FIFO requests, [0]=T0 [1]=T1 [2]=R0 [3]=R1 |
| single_req | input | 1 | Single-access path request |
| xfer_done | input | 1 | Pulse ending the granted transaction |
| policy | input | 2 | 00 rotating, 01 priority, 10 external, 11 reserved |
| prio_vals | input | 8 | Two-bit priority per FIFO, FIFO i at [2i+1:2i] |
| ext_sel | input | 2 | External winner: 00=R1 01=R0 10=T1 11=T0 |
| req_status | output | 4 | Registered requests: [0]=R1 [1]=R0 [2]=T1 [3]=T0 |
| grant | output | 5 | One-hot registered grant, [4]=S |

## Verification
Some properties are checked by assertions on every cycle:

- the grant is at most one-hot and goes only to a source that was requesting;
- a held grant is stable until done, and done clears it;
- S wins whenever it requests from the idle state;
- idle inputs and the reserved policy produce no FIFO grant;
- the status vector keeps its bit mapping.

Other behaviour depends on history or on programmed values, so only the bench's scenarios can show it:

- the rotation order and its restart point after S grants and skipped FIFOs;
- which FIFO wins under particular priority values and ties;
- the mapping from each select code to its FIFO.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NUM_FIFO = 4;
  localparam int PRIO_W   = 2;
  localparam int IDX_W    = $clog2(NUM_FIFO);
  localparam int GNT_W    = NUM_FIFO + 1;

  typedef enum logic [1:0] {
    POL_ROTATE   = 2'b00,
    POL_PRIORITY = 2'b01,
    POL_EXTERNAL = 2'b10,
    POL_RESERVED = 2'b11
  } policy_t;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          valid,
  output logic [IW-1:0] idx
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (int'(last) + k) % N;
      if (!valid && req[j]) begin
        valid = 1'b1;
        idx   = IW'(j);
      end
    end
  end
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N  = 4,
  parameter int PW = 2,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]    req,
  input  logic [N*PW-1:0] prio,
  output logic            valid,
  output logic [IW-1:0]   idx
);
  logic [PW-1:0] best;

  always_comb begin
    valid = 1'b0;
    idx   = '0;
    best  = '0;
    // strict compare: earlier index keeps ties
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!valid || prio[i*PW +: PW] > best)) begin
        valid = 1'b1;
        idx   = IW'(i);
        best  = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/ext_pick.sv
module ext_pick #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] sel,
  output logic          valid,
  output logic [IW-1:0] idx
);
  // select code counts down from the last FIFO
  assign idx   = IW'(N - 1) - sel;
  assign valid = req[idx];
endmodule

// File: rtl/bus_master_arbiter.sv
module bus_master_arbiter
  import arb_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_FIFO-1:0]        fifo_req,
  input  logic                       single_req,
  input  logic                       xfer_done,
  input  logic [1:0]                 policy,
  input  logic [NUM_FIFO*PRIO_W-1:0] prio_vals,
  input  logic [IDX_W-1:0]           ext_sel,
  output logic [NUM_FIFO-1:0]        req_status,
  output logic [GNT_W-1:0]           grant
);
  localparam int S_BIT = NUM_FIFO;

  policy_t              pol;
  logic [IDX_W-1:0]     last_q;
  logic                 rr_v, pr_v, ex_v, fifo_win;
  logic [IDX_W-1:0]     rr_i, pr_i, ex_i, win_idx;
  logic [GNT_W-1:0]     next_gnt;
  logic [NUM_FIFO-1:0]  status_d;
  logic                 busy;

  assign pol  = policy_t'(policy);
  assign busy = |grant;

  rr_pick #(.N(NUM_FIFO)) u_rr (
    .req(fifo_req), .last(last_q), .valid(rr_v), .idx(rr_i));

  prio_pick #(.N(NUM_FIFO), .PW(PRIO_W)) u_prio (
    .req(fifo_req), .prio(prio_vals), .valid(pr_v), .idx(pr_i));

  ext_pick #(.N(NUM_FIFO)) u_ext (
    .req(fifo_req), .sel(ext_sel), .valid(ex_v), .idx(ex_i));

  always_comb begin
    fifo_win = 1'b0;
    win_idx  = '0;
    unique case (pol)
      POL_ROTATE:   begin fifo_win = rr_v; win_idx = rr_i; end
      POL_PRIORITY: begin fifo_win = pr_v; win_idx = pr_i; end
      POL_EXTERNAL: begin fifo_win = ex_v; win_idx = ex_i; end
      default:      begin fifo_win = 1'b0; win_idx = '0;   end
    endcase
    next_gnt = '0;
    if (single_req)    next_gnt[S_BIT]   = 1'b1;
    else if (fifo_win) next_gnt[win_idx] = 1'b1;
  end

  generate
    for (genvar g = 0; g < NUM_FIFO; g++) begin : g_status
      assign status_d[g] = fifo_req[NUM_FIFO-1-g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      grant      <= '0;
      last_q     <= IDX_W'(NUM_FIFO - 1);
      req_status <= '0;
    end else begin
      req_status <= status_d;
      if (busy) begin
        if (xfer_done) grant <= '0;
      end else begin
        grant <= next_gnt;
        if (!single_req && fifo_win) last_q <= win_idx;
      end
    end
  end

  // R2: at most one grant bit
  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R2: a new grant goes only to a source that was requesting
  p_grant_to_requester_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |=> ((grant & $past({single_req, fifo_req})) == grant));

  // R3: single access wins from idle
  p_single_wins_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && single_req) |=> grant[S_BIT]);

  // R4: grant held until done
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !xfer_done) |=> grant == $past(grant));

  // R4: done releases the grant
  p_release_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && xfer_done) |=> grant == '0);

  // R5: rotating policy never idles with a FIFO waiting
  p_rotate_serves_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy && pol == POL_ROTATE && |fifo_req) |=> busy);

  // R10: reserved policy grants no FIFO
  p_reserved_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && pol == POL_RESERVED && !single_req) |=> grant == '0);

  // R11: status vector mapping
  p_status_map_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (req_status[0] == $past(fifo_req[NUM_FIFO-1]) &&
              req_status[NUM_FIFO-1] == $past(fifo_req[0])));

  // R12: idle stays idle
  p_idle_r12: assert property (@(posedge clk) disable iff (rst)
    (!busy && !single_req && fifo_req == '0) |=> grant == '0);
endmodule

// File: tb/bus_master_arbiter_tb_top.sv
module bus_master_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] fifo_req = '0;
  logic       single_req = 1'b0;
  logic       xfer_done = 1'b0;
  logic [1:0] policy = 2'b00;
  logic [7:0] prio_vals = '0;
  logic [1:0] ext_sel = '0;
  logic [3:0] req_status;
  logic [4:0] grant;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [4:0] gnt;
    logic [3:0] stat;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_master_arbiter dut_i (
    .clk(clk), .rst(rst), .fifo_req(fifo_req), .single_req(single_req),
    .xfer_done(xfer_done), .policy(policy), .prio_vals(prio_vals),
    .ext_sel(ext_sel), .req_status(req_status), .grant(grant));

  localparam logic [4:0] G_NONE = 5'b00000, G_T0 = 5'b00001, G_T1 = 5'b00010,
                         G_R0 = 5'b00100, G_R1 = 5'b01000, G_S = 5'b10000;

  // driver: applies one cycle of inputs and queues the expected result
  task automatic cyc(input logic [3:0] rq, input logic s, input logic [1:0] pol,
                     input logic [1:0] sel, input logic dn,
                     input logic [4:0] eg, input string tag);
    exp_t e;
    @(negedge clk);
    fifo_req = rq; single_req = s; policy = pol; ext_sel = sel; xfer_done = dn;
    e.gnt  = eg;
    e.stat = {rq[0], rq[1], rq[2], rq[3]};
    e.tag  = tag;
    sb_q.push_back(e);
  endtask

  // grant then release through done
  task automatic win(input logic [3:0] rq, input logic s, input logic [1:0] pol,
                     input logic [1:0] sel, input logic [4:0] eg, input string tag);
    cyc(rq, s, pol, sel, 1'b0, eg, tag);
    cyc(rq, s, pol, sel, 1'b1, G_NONE, {tag, " release R4"});
  endtask

  // monitor: compares after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (grant !== e.gnt) begin
          errors++;
          $display("FAIL %s: grant actual=%b expected=%b", e.tag, grant, e.gnt);
        end
        checks++;
        if (req_status !== e.stat) begin
          errors++;
          $display("FAIL %s R11: req_status actual=%b expected=%b", e.tag, req_status, e.stat);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (grant !== G_NONE || req_status !== 4'b0000) begin
      errors++;
      $display("FAIL R1 reset: grant=%b status=%b expected 00000/0000", grant, req_status);
    end
    rst = 1'b0;

    // R12 idle, R1 rotation starts at T0, R5 order
    cyc(4'b0000, 0, 2'b00, 2'b00, 0, G_NONE, "R12 idle");
    cyc(4'b0000, 0, 2'b00, 2'b00, 1, G_NONE, "R12 done while idle");
    cyc(4'b1111, 0, 2'b00, 2'b00, 0, G_T0, "R1 R5 first is T0");
    cyc(4'b1111, 1, 2'b00, 2'b00, 0, G_T0, "R4 hold against single");
    cyc(4'b1111, 0, 2'b00, 2'b00, 1, G_NONE, "R4 release");
    win(4'b1111, 0, 2'b00, 2'b00, G_T1, "R5 T1");
    win(4'b1111, 0, 2'b00, 2'b00, G_R0, "R5 R0");
    win(4'b1111, 0, 2'b00, 2'b00, G_R1, "R5 R1");
    win(4'b1111, 0, 2'b00, 2'b00, G_T0, "R5 wrap T0");
    win(4'b1000, 0, 2'b00, 2'b00, G_R1, "R5 skip to R1");
    win(4'b0110, 0, 2'b00, 2'b00, G_T1, "R5 after R1 start T0 skip");
    // R3 single wins; rotation unchanged
    win(4'b1111, 1, 2'b00, 2'b00, G_S, "R3 single in rotate");
    win(4'b1111, 0, 2'b00, 2'b00, G_R0, "R5 pointer kept over single");

    // R6/R7 priority
    prio_vals = {2'd0, 2'd3, 2'd3, 2'd1};   // R1 R0 T1 T0
    win(4'b1111, 0, 2'b01, 2'b00, G_T1, "R7 tie T1 over R0");
    prio_vals = {2'd3, 2'd0, 2'd0, 2'd0};
    win(4'b1111, 0, 2'b01, 2'b00, G_R1, "R6 highest R1");
    prio_vals = {2'd2, 2'd2, 2'd2, 2'd2};
    win(4'b1111, 0, 2'b01, 2'b00, G_T0, "R7 all equal T0");
    win(4'b1100, 0, 2'b01, 2'b00, G_R0, "R7 R0 over R1");
    prio_vals = {2'd1, 2'd2, 2'd0, 2'd3};
    win(4'b1110, 0, 2'b01, 2'b00, G_R0, "R6 T0 not requesting");
    win(4'b1111, 1, 2'b01, 2'b00, G_S, "R3 single in priority");

    // R8/R9 external
    win(4'b1111, 0, 2'b10, 2'b00, G_R1, "R8 sel00 R1");
    win(4'b1111, 0, 2'b10, 2'b01, G_R0, "R8 sel01 R0");
    win(4'b1111, 0, 2'b10, 2'b10, G_T1, "R8 sel10 T1");
    win(4'b1111, 0, 2'b10, 2'b11, G_T0, "R8 sel11 T0");
    cyc(4'b0010, 0, 2'b10, 2'b01, 0, G_NONE, "R9 R0 not pending");
    cyc(4'b0001, 0, 2'b10, 2'b10, 0, G_NONE, "R9 T1 not pending");
    win(4'b1111, 1, 2'b10, 2'b11, G_S, "R3 single in external");

    // R10 reserved
    cyc(4'b1111, 0, 2'b11, 2'b11, 0, G_NONE, "R10 reserved no FIFO");
    cyc(4'b0101, 0, 2'b11, 2'b00, 0, G_NONE, "R10 reserved again");
    win(4'b1111, 1, 2'b11, 2'b00, G_S, "R3 single in reserved");
    cyc(4'b0000, 0, 2'b00, 2'b00, 0, G_NONE, "R12 final idle");

    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule